// File: doc/BRIEF.md
# Pulse-Width Coded Single-Wire Transmitter

This block sends bytes over one wire that carries both timing and data. Each bit takes a bit cycle of fixed length. The cycle opens with a low pulse whose width is the bit value: a short low pulse means one and a long low pulse means zero. For the rest of the cycle the wire is high, which gives the far end time to recover. A byte arrives on a valid/ready handshake and goes out as eight bit cycles, most significant bit first. Between bytes the wire rests high.

All durations are parameters counted in system clock cycles. The defaults are a 60-clock bit cycle, a 1-clock low pulse for a one and a 30-clock low pulse for a zero. At a 1 MHz tick these give the usual 60 µs / 1 µs / 30 µs timing.

A hold request lets the host stop the wire from being discharged while the host is busy. The block acts on a hold only at the edge of a bit cycle, so a pulse that has started always runs to full length. While holding, the output enable drops and the wire floats. When the hold is released, any remaining bits go out, each with a fresh bit cycle.

Top module: `pwl_tx`

## Requirements
- R1: After reset, with `hold_req` low, `line_o` is 1, `line_oe` is 1 and `in_ready` is 1.
- R2: A byte is taken at a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until that byte has been fully sent.
- R3: The first bit cycle starts in the clock cycle right after acceptance. Every bit cycle lasts `CYCLE_LEN` clocks, and `in_data[7]` is sent first.
- R4: A bit of value 1 drives `line_o` to 0 for the first `ONE_LOW` clocks of its cycle and to 1 for the rest of the cycle.
- R5: A bit of value 0 drives `line_o` to 0 for the first `ZERO_LOW` clocks of its cycle and to 1 for the rest of the cycle.
- R6: Exactly 8×`CYCLE_LEN` clocks after the acceptance edge, the block is idle again: `line_o` is 1, `line_oe` is 1 and `in_ready` is 1.
- R7: If `hold_req` is 1 at the clock edge that ends a bit cycle, `line_oe` goes to 0 from the next cycle onward and stays 0 while `hold_req` remains 1. The edge that first sees `hold_req` at 0 starts the next unsent bit as a fresh cycle. If no bits remain, that edge returns the block to idle.
- R8: While idle and `hold_req` is 1, `in_ready` is 0 and `in_valid` is ignored. From the next edge `line_oe` is 0. After release, the block is idle with nothing sent.
- R9: A hold raised partway through a bit cycle has no effect until that cycle ends. `line_oe` stays 1 and the pulse is not cut short.
- R10: While enabled, `line_o` is never 0 for more than `ZERO_LOW` consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | DATA_W | Byte to send, MSB first |
| in_ready | output | 1 | Block can take a byte this cycle |
| hold_req | input | 1 | Request to float the wire at the next bit boundary |
| line_o | output | 1 | Wire level to drive |
| line_oe | output | 1 | Wire driver enable (0 = high impedance) |

## Verification
Each result has a fixed cycle at which it is due, counted from the edge that takes a byte. Cycle t of bit k falls at offset k×CYCLE_LEN+t after that edge, so the expected level of `line_o` is known for every clock. The idle state is due exactly at offset 8×CYCLE_LEN. The bench drives inputs and samples outputs on the falling clock edge. It compares every clock of every bit against a level it works out from the bit value and the position in the cycle. A hold takes effect one edge after the bit boundary that sees it, and a release takes effect one edge after `hold_req` falls. The hold checks sample at those exact offsets.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2
  } tx_state_e;

  // Timing legality: both pulse widths non-zero, one shorter than zero,
  // and both strictly inside the bit cycle.
  function automatic bit timing_ok(input int unsigned one_low,
                                   input int unsigned zero_low,
                                   input int unsigned cycle_len);
    return (one_low >= 1) && (one_low < zero_low) && (zero_low < cycle_len);
  endfunction

endpackage

// File: rtl/pwl_bit_timer.sv
module pwl_bit_timer #(
  parameter int unsigned CYCLE_LEN = 60,
  parameter int unsigned ONE_LOW   = 1,
  parameter int unsigned ZERO_LOW  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bit_val,
  output logic cycle_end,
  output logic low_phase
);
  localparam int unsigned CW = $clog2(CYCLE_LEN);
  localparam logic [CW-1:0] LAST_IDX = CW'(CYCLE_LEN - 1);
  localparam logic [CW-1:0] ONE_W    = CW'(ONE_LOW);
  localparam logic [CW-1:0] ZERO_W   = CW'(ZERO_LOW);

  logic [CW-1:0] cnt;

  // Width of the low pulse for a given bit value.
  function automatic logic [CW-1:0] low_width(input logic b);
    return b ? ONE_W : ZERO_W;
  endfunction

  assign cycle_end = run && (cnt == LAST_IDX);
  assign low_phase = run && (cnt < low_width(bit_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (cycle_end) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwl_shifter.sv
module pwl_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  output logic              cur_bit,
  output logic              last_bit,
  output logic              more_bits
);
  localparam int unsigned LW = $clog2(DATA_W + 1);
  localparam logic [LW-1:0] FULL = LW'(DATA_W);

  logic [DATA_W-1:0] sr;
  logic [LW-1:0]     left;

  assign cur_bit   = sr[DATA_W-1];
  assign last_bit  = (left == LW'(1));
  assign more_bits = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      left <= '0;
    end else if (load) begin
      sr   <= load_data;
      left <= FULL;
    end else if (shift) begin
      sr   <= {sr[DATA_W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/pwl_ctrl.sv
module pwl_ctrl
  import pwl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  logic      hold_req,
  input  logic      cycle_end,
  input  logic      last_bit,
  input  logic      more_bits,
  output tx_state_e state,
  output logic      in_ready,
  output logic      load
);
  tx_state_e nxt;

  assign in_ready = (state == ST_IDLE) && !hold_req;
  assign load     = in_valid && in_ready;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (hold_req)      nxt = ST_HOLD;
        else if (in_valid) nxt = ST_SEND;
      end
      ST_SEND: begin
        if (cycle_end) begin
          if (hold_req)      nxt = ST_HOLD;
          else if (last_bit) nxt = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (!hold_req) nxt = more_bits ? ST_SEND : ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/pwl_tx.sv
module pwl_tx
  import pwl_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CYCLE_LEN = 60,
  parameter int unsigned ONE_LOW   = 1,
  parameter int unsigned ZERO_LOW  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              hold_req,
  output logic              line_o,
  output logic              line_oe
);
  generate
    if (!timing_ok(ONE_LOW, ZERO_LOW, CYCLE_LEN)) begin : g_bad_timing
      $error("pwl_tx: pulse widths must satisfy 1 <= ONE_LOW < ZERO_LOW < CYCLE_LEN");
    end
  endgenerate

  tx_state_e state;
  logic      load, cycle_end, low_phase;
  logic      cur_bit, last_bit, more_bits;

  // Named internal events for the checker.
  logic st_send, st_hold, bit_end, at_boundary;
  assign st_send     = (state == ST_SEND);
  assign st_hold     = (state == ST_HOLD);
  assign bit_end     = cycle_end;
  assign at_boundary = (state == ST_IDLE) || bit_end;

  pwl_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hold_req(hold_req),
    .cycle_end(cycle_end), .last_bit(last_bit), .more_bits(more_bits),
    .state(state), .in_ready(in_ready), .load(load)
  );

  pwl_bit_timer #(.CYCLE_LEN(CYCLE_LEN), .ONE_LOW(ONE_LOW), .ZERO_LOW(ZERO_LOW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st_send), .bit_val(cur_bit),
    .cycle_end(cycle_end), .low_phase(low_phase)
  );

  pwl_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(in_data),
    .shift(cycle_end), .cur_bit(cur_bit), .last_bit(last_bit),
    .more_bits(more_bits)
  );

  assign line_oe = !st_hold;
  assign line_o  = !low_phase;
endmodule

// File: rtl/pwl_tx_chk.sv
module pwl_tx_chk #(
  parameter int unsigned ZERO_LOW = 30
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic hold_req,
  input logic line_o,
  input logic line_oe,
  input logic at_boundary,
  input logic st_hold
);
  logic [31:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  low_run <= '0;
    else if (line_oe && !line_o) low_run <= low_run + 1;
    else                         low_run <= '0;
  end

  AST_READY_IMPLIES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (line_o && line_oe)); // R1
  AST_ACCEPT_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!line_o && !in_ready)); // R3
  AST_OE_ONLY_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> $past(hold_req)); // R7
  AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> $past(at_boundary)); // R9
  AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    st_hold |-> !in_ready); // R8
  AST_LOW_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && !line_o) |-> (low_run < ZERO_LOW)); // R10
endmodule

bind pwl_tx pwl_tx_chk #(.ZERO_LOW(ZERO_LOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .hold_req(hold_req), .line_o(line_o), .line_oe(line_oe),
  .at_boundary(at_boundary), .st_hold(st_hold)
);

// File: tb/tb_pwl_tx.sv
`timescale 1ns/1ps
module tb_pwl_tx;
  localparam int C  = 60;
  localparam int W1 = 1;
  localparam int W0 = 30;
  localparam int NV = 6;
  localparam logic [7:0] VEC [0:NV-1] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, hold_req = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, line_o, line_oe;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pwl_tx #(.DATA_W(8), .CYCLE_LEN(C), .ONE_LOW(W1), .ZERO_LOW(W0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .hold_req(hold_req), .line_o(line_o), .line_oe(line_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Packs {line_o, line_oe, in_ready}
  function automatic int pins();
    return {29'd0, line_o, line_oe, in_ready};
  endfunction

  task automatic send(input logic [7:0] d);
    check(in_ready === 1'b1, "R2 ready before offer", int'(in_ready), 1);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0; in_data = 8'h00;
    check(in_ready === 1'b0, "R2 ready drops after accept", int'(in_ready), 0);
  endtask

  // Checks bits first..last, one clock at a time; starts at cycle 0 of bit 'first'.
  task automatic run_bits(input logic [7:0] d, input int first, input int last);
    for (int k = first; k <= last; k++) begin
      logic b = d[7-k];
      int w = b ? W1 : W0;
      int errs = 0;
      int first_bad = 0;
      for (int c = 0; c < C; c++) begin
        logic exp_line = (c < w) ? 1'b0 : 1'b1;
        if (line_o !== exp_line || line_oe !== 1'b1 || in_ready !== 1'b0) begin
          if (errs == 0) first_bad = pins();
          errs++;
        end
        @(negedge clk);
      end
      if (b) check(errs == 0, "R4 R3 one-bit pulse", first_bad, k);
      else   check(errs == 0, "R5 R3 zero-bit pulse", first_bad, k);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pins() == 7, "R1 reset idle", pins(), 7);

    // Table-driven byte transfers
    for (int v = 0; v < NV; v++) begin
      send(VEC[v]);
      run_bits(VEC[v], 0, 7);
      check(pins() == 7, "R6 idle after 8 bit cycles", pins(), 7);
    end

    // R9 / R7: hold raised mid-bit, honoured at boundary, resume remaining bits
    send(8'hA5);
    for (int c = 0; c < C; c++) begin
      if (c == C - 5) hold_req = 1'b1;
      if (c == C - 1) check(line_oe === 1'b1 && line_o === 1'b1, "R9 no truncation", pins(), 6);
      @(negedge clk);
    end
    check(line_oe === 1'b0, "R7 float at boundary", int'(line_oe), 0);
    for (int i = 0; i < 10; i++) @(negedge clk);
    check(line_oe === 1'b0 && in_ready === 1'b0, "R7 stays floating", pins(), 0);
    hold_req = 1'b0;
    @(negedge clk);
    run_bits(8'hA5, 1, 7);
    check(pins() == 7, "R6 idle after resumed byte", pins(), 7);

    // R7: hold at end of last bit returns to idle on release
    send(8'h3C);
    run_bits(8'h3C, 0, 6);
    for (int c = 0; c < C; c++) begin
      if (c == C - 3) hold_req = 1'b1;
      @(negedge clk);
    end
    check(line_oe === 1'b0 && in_ready === 1'b0, "R7 hold after last bit", pins(), 0);
    hold_req = 1'b0;
    @(negedge clk);
    check(pins() == 7, "R7 release to idle", pins(), 7);

    // R8: hold while idle, offered byte ignored
    hold_req = 1'b1;
    #0;
    check(in_ready === 1'b0, "R8 ready low under hold", int'(in_ready), 0);
    in_valid = 1'b1; in_data = 8'h00;
    @(negedge clk);
    check(line_oe === 1'b0, "R8 floats from idle", int'(line_oe), 0);
    for (int i = 0; i < 5; i++) @(negedge clk);
    in_valid = 1'b0;
    hold_req = 1'b0;
    @(negedge clk);
    begin
      int lows = 0;
      for (int i = 0; i < 20; i++) begin
        if (line_o !== 1'b1 || line_oe !== 1'b1) lows++;
        @(negedge clk);
      end
      check(lows == 0 && in_ready === 1'b1, "R8 ignored byte not sent", lows, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule